// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is the serial chain of boundary cells placed between a chip's pads and its core logic. It has one group of cells on the input side, between the input pins and the core inputs, and one group on the output side, between the core outputs and the output pins. Each cell holds two bits:

- a capture/shift bit, which either takes a parallel snapshot or passes data along the serial path;
- an update bit, which holds the value that the cell applies when it is in test mode.

A test controller drives the block through its control inputs: capture, shift, update and the per-cell mode masks. With every mode bit at 0 the functional paths pass straight through, so the chain can sample the pins and preload new data without disturbing normal operation. Setting the output-side mode bits drives the pins from the update stage, which gives external interconnect test. Setting the input-side mode bits feeds the core from the update stage, which gives internal test. In both cases the next capture records the response, and the following shift scans that response out while the next pattern scans in.

Top module: `bsr_chain`

## Requirements
- R1: While `rst_n` is low every update bit is 0, without waiting for a clock edge. A cell whose mode bit is 1 then drives 0.
- R2: A cell whose mode bit is 0 passes its functional input through combinationally (`core_in[i]=pin_in[i]`, `pin_out[j]=core_out[j]`), whatever its stored bits hold.
- R3: On a rising `clk` edge with `capture_en`=1 and `shift_en`=0, the input-side capture bit i loads `pin_in[i]` and the output-side capture bit j loads `core_out[j]`.
- R4: Chain position k is input cell k for k<N_IN and output cell k-N_IN otherwise. On a rising edge with `shift_en`=1, position 0 loads `scan_in` and position k loads position k-1. `scan_out` shows the last position, so the first bit out after a capture is `core_out[N_OUT-1]`.
- R5: On an edge with neither `capture_en` nor `shift_en` set, the capture bits hold their values.
- R6: The update bits load from the capture bits only on an edge with `update_en`=1. Shifting or capturing leaves the values driven in test mode unchanged.
- R7: A cell whose mode bit is 1 drives its update bit. This is chosen per cell, so masks with both 0 and 1 bits are allowed.
- R8: When `shift_en` and `capture_en` are both 1, the shift takes place and the capture does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the chain |
| scan_in | input | 1 | Serial data into chain position 0 |
| shift_en | input | 1 | Shift the chain by one position |
| capture_en | input | 1 | Load the parallel inputs into the capture bits |
| update_en | input | 1 | Copy the capture bits into the update bits |
| in_mode | input | N_IN | Per input cell: 1 feeds the core from the update bit |
| out_mode | input | N_OUT | Per output cell: 1 drives the pin from the update bit |
| pin_in | input | N_IN | Values on the input pins |
| core_out | input | N_OUT | Values from the core logic outputs |
| scan_out | output | 1 | Serial data from the last chain position |
| core_in | output | N_IN | Values delivered to the core inputs |
| pin_out | output | N_OUT | Values delivered to the output pins |

## Verification
Four capture-and-preload vectors each use different pin and core patterns. Reading back the captured bits separates the input-side cells from the output-side cells and shows the order in which bits leave the chain. The preload values, once updated, show whether each update bit reaches the correct core input or pin. Directed cases use mixed mode masks, which expose a swapped or shared mode select. A partial shift with the pins held under test mode shows whether the update stage is properly isolated from the shift path. Raising capture and shift together, with the two possible results chosen to differ, shows which one takes priority.

// File: rtl/bsr_chain.sv
module bsr_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_in,
  input  logic             shift_en,
  input  logic             capture_en,
  input  logic             update_en,
  input  logic [N_IN-1:0]  in_mode,
  input  logic [N_OUT-1:0] out_mode,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_OUT-1:0] core_out,
  output logic             scan_out,
  output logic [N_IN-1:0]  core_in,
  output logic [N_OUT-1:0] pin_out
);
  localparam int L = N_IN + N_OUT;

  logic [L-1:0] cap_q;
  logic [L-1:0] upd_q;
  logic [L-1:0] par_d;

  assign par_d = {core_out, pin_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cap_q <= '0;
    else if (shift_en)
      cap_q <= {cap_q[L-2:0], scan_in};
    else if (capture_en)
      cap_q <= par_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      upd_q <= '0;
    else if (update_en)
      upd_q <= cap_q;
  end

  assign scan_out = cap_q[L-1];

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    assign core_in[i] = in_mode[i] ? upd_q[i] : pin_in[i];
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    assign pin_out[j] = out_mode[j] ? upd_q[N_IN+j] : core_out[j];
  end
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scan_in,
  input logic                   shift_en,
  input logic                   capture_en,
  input logic                   update_en,
  input logic [N_IN-1:0]        in_mode,
  input logic [N_OUT-1:0]       out_mode,
  input logic [N_IN-1:0]        pin_in,
  input logic [N_OUT-1:0]       core_out,
  input logic                   scan_out,
  input logic [N_IN-1:0]        core_in,
  input logic [N_OUT-1:0]       pin_out,
  input logic [N_IN+N_OUT-1:0]  cap_q,
  input logic [N_IN+N_OUT-1:0]  upd_q
);
  localparam int L = N_IN + N_OUT;

  always_ff @(posedge clk)
    if (!rst_n) AST_RESET_CLEAR: assert (upd_q == '0); // R1

  AST_MODE0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_mode == '0 && out_mode == '0) |-> (core_in == pin_in && pin_out == core_out)); // R2

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && !shift_en) |=> cap_q == $past({core_out, pin_in})); // R3

  AST_SHIFT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> scan_out == $past(cap_q[L-2])); // R4

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !capture_en) |=> $stable(cap_q)); // R5

  AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !update_en |=> $stable(upd_q)); // R6

  AST_UPD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    update_en |=> upd_q == $past(cap_q)); // R6

  AST_MODE1_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (&out_mode) |-> pin_out == upd_q[L-1:N_IN]); // R7

  AST_SHIFT_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && capture_en) |=> cap_q[0] == $past(scan_in)); // R8
endmodule

bind bsr_chain bsr_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (.*);

// File: tb/tb_bsr_chain.sv
`timescale 1ns/1ps
module tb_bsr_chain;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int L  = NI + NO;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_in = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
  logic [NI-1:0] in_mode = '0, pin_in = '0, core_in;
  logic [NO-1:0] out_mode = '0, core_out = '0, pin_out;
  logic scan_out;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bsr_chain #(.N_IN(NI), .N_OUT(NO)) dut (.*);

  // {pin_in, core_out, preload}
  localparam logic [15:0] VEC [4] = '{
    16'h3C_96, 16'hA5_0F, 16'h6E_F0, 16'h19_A5
  };

  task automatic check(string req, logic [L-1:0] act, logic [L-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [L-1:0] rx, pl, exp;
    logic s0;
    in_mode = '1; out_mode = '1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset core_in", L'(core_in), '0);
    check("R1 reset pin_out", L'(pin_out), '0);
    rst_n = 1'b1;
    in_mode = '0; out_mode = '0;

    for (int v = 0; v < 4; v++) begin
      pin_in = VEC[v][15:12]; core_out = VEC[v][11:8]; pl = VEC[v][7:0];
      in_mode = '0; out_mode = '0;
      capture_en = 1'b1;
      @(negedge clk);
      capture_en = 1'b0; shift_en = 1'b1;
      for (int k = 0; k < L; k++) begin
        rx[L-1-k] = scan_out;
        scan_in = pl[L-1-k];
        @(negedge clk);
      end
      shift_en = 1'b0;
      check("R3 R4 captured bits", rx, {core_out, pin_in});
      update_en = 1'b1;
      @(negedge clk);
      update_en = 1'b0;
      in_mode = '1; out_mode = '1;
      #1;
      check("R7 core_in from update", L'(core_in), L'(pl[NI-1:0]));
      check("R7 pin_out from update", L'(pin_out), L'(pl[L-1:NI]));
    end

    // mode 0 passes through whatever the update bits hold
    in_mode = '0; out_mode = '0; pin_in = 4'h9; core_out = 4'h6;
    #1;
    check("R2 core_in pass", L'(core_in), L'(4'h9));
    check("R2 pin_out pass", L'(pin_out), L'(4'h6));

    // mixed masks
    in_mode = 4'b0101; out_mode = 4'b1100;
    #1;
    check("R7 mixed core_in", L'(core_in), L'({pin_in[3], pl[2], pin_in[1], pl[0]}));
    check("R7 mixed pin_out", L'(pin_out), L'({pl[7], pl[6], core_out[1], core_out[0]}));

    // partial shift under test mode: pins unchanged until update
    in_mode = '1; out_mode = '1;
    @(negedge clk);
    shift_en = 1'b1; scan_in = 1'b1;
    repeat (3) @(negedge clk);
    shift_en = 1'b0;
    #1;
    check("R6 pin_out stable during shift", L'(pin_out), L'(pl[L-1:NI]));
    exp = {pl[L-4:0], 3'b111};
    s0 = scan_out;
    core_out = ~core_out; pin_in = ~pin_in;
    repeat (2) @(negedge clk);
    check("R5 hold without capture/shift", L'(scan_out), L'(s0));
    check("R4 position after 3 shifts", L'(s0), L'(exp[L-1]));
    update_en = 1'b1;
    @(negedge clk);
    update_en = 1'b0;
    #1;
    check("R6 update after shift core_in", L'(core_in), L'(exp[NI-1:0]));
    check("R6 update after shift pin_out", L'(pin_out), L'(exp[L-1:NI]));

    // shift and capture together: shift wins
    core_out = {~exp[L-2], 3'b000}; pin_in = '0;
    capture_en = 1'b1; shift_en = 1'b1; scan_in = 1'b0;
    @(negedge clk);
    capture_en = 1'b0; shift_en = 1'b0;
    check("R8 shift over capture", L'(scan_out), L'(exp[L-2]));

    // async reset clears update stage at once
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async clear core_in", L'(core_in), '0);
    check("R1 async clear pin_out", L'(pin_out), '0);
    finish_run();
  end
endmodule